// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Receiver

This block watches a one-bit infrared demodulator output and measures how long each high interval (pulse) and each low interval (space) lasts. The unit of measure is a programmable sample tick. Each measured interval is written as one byte into a 68-slot capture store, which software reads as 17 words of 32 bits. A capture begins on the first accepted rising edge. It ends when a space runs longer than a programmed end-of-message limit. At that point the block marks that slot with zero, clears every later slot and raises an interrupt.

The input passes through a two-flop synchronizer and then a majority-free agreement filter. A level change is accepted only after a programmed number of consecutive ticks all see the new level. Software programs the tick period, the filter length and the end-of-message count through a small synchronous register port. It then enables the receiver, waits for the interrupt, reads the capture words, and writes a restart and an interrupt clear before the next message.

Top module: `ir_pw_capture`

## Requirements
- R1: After an accepted rising edge, stored slots alternate pulse, space, pulse and so on, starting with a pulse. Each value is the interval length in sample ticks.
- R2: An interval of more than 255 ticks is stored as 8'hFF.
- R3: A space lasting more than LIMIT ticks ends the message, where LIMIT = eom_count × 4. The current slot and all later slots read 0, and status bit 0 at address 0x06 becomes 1. A space of exactly LIMIT ticks is stored normally.
- R4: Slot k is found in capture word k/4 at register address 0x10 + k/4, in bits 8·(k mod 4)+7 down to 8·(k mod 4).
- R5: Once all 68 slots are written, further edges change no slot. The interrupt still follows the next over-long space.
- R6: Writing 1 to bit 0 of address 0x03 clears every capture word to 0 and returns capture to idle.
- R7: irq_o is the status bit gated by bit 0 of address 0x04. Writing 1 to bit 0 of address 0x05 clears the status.
- R8: Capture runs only while both bit 0 (receive enable) and bit 13 (width-detect enable) of address 0x00 are 1. Clearing either one returns capture to idle without setting the status.
- R9: A level change is accepted only after dg consecutive ticks see the new level, where dg is taken from bits 12:8 of address 0x01 (reset value 1). A shorter glitch leaves the store untouched.
- R10: Bits 15:0 of address 0x02 hold a value P. A sample tick occurs once every P+1 clock cycles.
- R11: While the status is pending after a message, new pulses start no capture until a restart.
- R12: After reset, irq_o is 0, the status is 0 and every capture word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Raw infrared demodulator output, high during a pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_o | output | 1 | Interrupt request |

## Verification
Embedded assertions check on every cycle the following properties:
- a new capture always starts on the high level;
- the write pointer never passes the last slot, and the store stays frozen once full;
- the status rises only on an end-of-message event, and a pending status holds the capture in its finished state;
- a disable forces idle;
- the filtered level changes only on a tick;
- ticks are spaced when the period is non-zero;
- a restart empties the store.

The actual byte values need the bench's scenarios, because they depend on whole stimulus histories. These cover packed widths, saturation, the exact end-of-message boundary, overflow of the 68 slots, glitch rejection, and tick scaling.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  // register word addresses
  localparam logic [5:0] A_CFG      = 6'h00;
  localparam logic [5:0] A_THRESH   = 6'h01;
  localparam logic [5:0] A_PERIOD   = 6'h02;
  localparam logic [5:0] A_RESTART  = 6'h03;
  localparam logic [5:0] A_INT_EN   = 6'h04;
  localparam logic [5:0] A_INT_CLR  = 6'h05;
  localparam logic [5:0] A_INT_STAT = 6'h06;
  localparam logic [5:0] A_CAP_BASE = 6'h10;

  // configuration field positions
  localparam int B_RX_EN  = 0;
  localparam int B_PW_EN  = 13;
  localparam int B_EOM_LO = 16;
  localparam int B_DG_LO  = 8;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CAPT = 2'd1,
    S_FULL = 2'd2,
    S_DONE = 2'd3
  } cap_state_e;

  // clamp a tick count to one storage byte
  function automatic logic [7:0] sat_byte(input logic [15:0] n);
    return (n > 16'd255) ? 8'hFF : n[7:0];
  endfunction

  // end-of-message limit in ticks
  function automatic logic [15:0] eom_ticks(input logic [15:0] eom, input int shift);
    return eom << shift;
  endfunction

endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  logic [PERIOD_W-1:0] div_q;

  assign tick_o = (div_q >= period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R10: with a non-zero period two ticks never sit back to back
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && period_i != '0) |=> (!tick_o || period_i == '0));

endmodule

// File: rtl/ir_deglitch.sv
module ir_deglitch #(
  parameter int DG_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ir_i,
  input  logic            tick_i,
  input  logic [DG_W-1:0] need_i,
  output logic            level_o,
  output logic            accept_o
);
  logic            sync1_q, sync2_q, filt_q;
  logic [DG_W-1:0] agree_q;
  logic [DG_W-1:0] need_eff;
  logic            differ;

  assign need_eff = (need_i == '0) ? DG_W'(1) : need_i;
  assign differ   = (sync2_q != filt_q);
  assign accept_o = tick_i && differ && (({1'b0, agree_q} + 1'b1) >= {1'b0, need_eff});
  assign level_o  = filt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      filt_q  <= 1'b0;
      agree_q <= '0;
    end else begin
      sync1_q <= ir_i;
      sync2_q <= sync1_q;
      if (!differ) begin
        agree_q <= '0;
      end else if (tick_i) begin
        if (accept_o) begin
          filt_q  <= sync2_q;
          agree_q <= '0;
        end else begin
          agree_q <= agree_q + 1'b1;
        end
      end
    end
  end

  // R9: the accepted level moves only on a sample tick
  p_change_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_o) |-> $past(tick_i));

endmodule

// File: rtl/ir_cap_store.sv
module ir_cap_store #(
  parameter int N_SLOTS = 68,
  parameter int PTR_W   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 wr_i,
  input  logic                 fill_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [7:0]           data_i,
  output logic [N_SLOTS*8-1:0] bytes_o
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              bytes_o[g*8 +: 8] <= '0;
      else if (clr_i)                          bytes_o[g*8 +: 8] <= '0;
      else if (fill_i && ptr_i <= PTR_W'(g))   bytes_o[g*8 +: 8] <= '0;
      else if (wr_i && ptr_i == PTR_W'(g))     bytes_o[g*8 +: 8] <= data_i;
    end
  end

  // R6: a restart leaves every slot empty
  p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (bytes_o == '0));

endmodule

// File: rtl/ir_pw_capture.sv
module ir_pw_capture
  import ir_cap_pkg::*;
#(
  parameter int PERIOD_W  = 16,
  parameter int DG_W      = 5,
  parameter int EOM_W     = 7,
  parameter int EOM_SHIFT = 2,
  parameter int N_SLOTS   = 68
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_in,
  input  logic        reg_wr,
  input  logic [5:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_o
);
  localparam int N_WORDS = N_SLOTS / 4;
  localparam int PTR_W   = $clog2(N_SLOTS + 1);
  localparam int WIDX_W  = $clog2(N_WORDS);
  localparam int CNT_W   = (EOM_W + EOM_SHIFT + 1 < 9) ? 9 : EOM_W + EOM_SHIFT + 1;

  // configuration state
  logic                rx_en_q, pw_en_q, int_en_q, int_stat_q;
  logic [EOM_W-1:0]    eom_q;
  logic [DG_W-1:0]     dg_q;
  logic [PERIOD_W-1:0] period_q;

  // named internal events
  logic tick, acc_edge, line_lvl, active;
  logic restart_req, clr_req, eom_evt, st_wr, st_fill;

  cap_state_e          state_q;
  logic [PTR_W-1:0]    ptr_q;
  logic [CNT_W-1:0]    cnt_q, cnt_inc, limit;
  logic [7:0]          wr_byte;
  logic [N_SLOTS*8-1:0] cap_bytes;
  logic [31:0]         cap_words [N_WORDS];

  assign restart_req = reg_wr && reg_addr == A_RESTART && reg_wdata[0];
  assign clr_req     = reg_wr && reg_addr == A_INT_CLR && reg_wdata[0];
  assign active      = rx_en_q && pw_en_q;
  assign limit       = CNT_W'(eom_ticks(16'(eom_q), EOM_SHIFT));
  assign cnt_inc     = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
  assign wr_byte     = sat_byte(16'(cnt_q));

  assign eom_evt = active && !restart_req && tick && !acc_edge && !line_lvl &&
                   (state_q == S_CAPT || state_q == S_FULL) && (cnt_q >= limit);
  assign st_wr   = active && !restart_req && acc_edge && state_q == S_CAPT;
  assign st_fill = eom_evt && state_q == S_CAPT;

  ir_tick_gen #(.PERIOD_W(PERIOD_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_q),
    .tick_o   (tick)
  );

  ir_deglitch #(.DG_W(DG_W)) u_dg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ir_i     (ir_in),
    .tick_i   (tick),
    .need_i   (dg_q),
    .level_o  (line_lvl),
    .accept_o (acc_edge)
  );

  ir_cap_store #(.N_SLOTS(N_SLOTS), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (restart_req),
    .wr_i    (st_wr),
    .fill_i  (st_fill),
    .ptr_i   (ptr_q),
    .data_i  (wr_byte),
    .bytes_o (cap_bytes)
  );

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign cap_words[w] = cap_bytes[w*32 +: 32];
  end

  // register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q  <= 1'b0;
      pw_en_q  <= 1'b0;
      eom_q    <= '0;
      dg_q     <= DG_W'(1);
      period_q <= '0;
      int_en_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_CFG: begin
          rx_en_q <= reg_wdata[B_RX_EN];
          pw_en_q <= reg_wdata[B_PW_EN];
          eom_q   <= reg_wdata[B_EOM_LO +: EOM_W];
        end
        A_THRESH: dg_q     <= reg_wdata[B_DG_LO +: DG_W];
        A_PERIOD: period_q <= reg_wdata[PERIOD_W-1:0];
        A_INT_EN: int_en_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // capture sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else if (restart_req || !active) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (acc_edge && !line_lvl) begin
            state_q <= S_CAPT;
            ptr_q   <= '0;
            cnt_q   <= CNT_W'(1);
          end
        end
        S_CAPT: begin
          if (acc_edge) begin
            ptr_q <= ptr_q + 1'b1;
            cnt_q <= CNT_W'(1);
            if (ptr_q == PTR_W'(N_SLOTS - 1)) state_q <= S_FULL;
          end else if (eom_evt) begin
            state_q <= S_DONE;
          end else if (tick) begin
            cnt_q <= cnt_inc;
          end
        end
        S_FULL: begin
          if (acc_edge)     cnt_q   <= CNT_W'(1);
          else if (eom_evt) state_q <= S_DONE;
          else if (tick)    cnt_q   <= cnt_inc;
        end
        default: ;
      endcase
    end
  end

  // interrupt status: a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       int_stat_q <= 1'b0;
    else if (eom_evt) int_stat_q <= 1'b1;
    else if (clr_req) int_stat_q <= 1'b0;
  end

  assign irq_o = int_stat_q && int_en_q;

  // register reads
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG: begin
        reg_rdata[B_RX_EN]             = rx_en_q;
        reg_rdata[B_PW_EN]             = pw_en_q;
        reg_rdata[B_EOM_LO +: EOM_W]   = eom_q;
      end
      A_THRESH:   reg_rdata[B_DG_LO +: DG_W]  = dg_q;
      A_PERIOD:   reg_rdata[PERIOD_W-1:0]     = period_q;
      A_INT_EN:   reg_rdata[0]                = int_en_q;
      A_INT_STAT: reg_rdata[0]                = int_stat_q;
      default: begin
        if (reg_addr >= A_CAP_BASE && (reg_addr - A_CAP_BASE) < 6'(N_WORDS))
          reg_rdata = cap_words[WIDX_W'(reg_addr - A_CAP_BASE)];
      end
    endcase
  end

  // R1: a capture always opens on the pulse level
  p_start_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CAPT && $past(state_q == S_IDLE)) |-> line_lvl);

  // R5: the write pointer never runs past the last slot
  p_ptr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PTR_W'(N_SLOTS));

  // R5: a full store is frozen
  p_full_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_FULL && !restart_req) |=> $stable(cap_bytes));

  // R3: status rises only after an end-of-message event
  p_stat_from_eom_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_stat_q) |-> $past(eom_evt));

  // R11: a finished capture waits for restart
  p_pending_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE && active && !restart_req) |=> state_q == S_DONE);

  // R8: disabling forces idle
  p_disable_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> state_q == S_IDLE);

endmodule

// File: tb/sim_ir_pw_capture.sv
module sim_ir_pw_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] exp_b [68];

  localparam logic [31:0] CFG_ON = 32'h0003_2001; // rx_en, pw_en, eom=3 -> limit 12 ticks
  localparam int N_VEC = 5;
  // pulse ticks, space ticks, pulses, requirement tag
  localparam int VEC [N_VEC][4] = '{
    '{5,   7,  3, 1},
    '{300, 9,  2, 2},
    '{4,   12, 4, 3},
    '{3,   3,  40, 5},
    '{2,   5,  6, 4}
  };

  always #10 clk = ~clk;

  ir_pw_capture u0 (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic hold(input logic lvl, input int cyc);
    @(negedge clk);
    ir_in = lvl;
    repeat (cyc - 1) @(negedge clk);
  endtask

  // drive a message and build the expected slot image
  task automatic send(input int p, input int s, input int n, input int scale, input int tail);
    int k = 0;
    foreach (exp_b[i]) exp_b[i] = 8'h00;
    for (int i = 0; i < n; i++) begin
      hold(1'b1, p * scale);
      if (k < 68) begin exp_b[k] = (p > 255) ? 8'hFF : 8'(p); k++; end
      if (i < n - 1) begin
        hold(1'b0, s * scale);
        if (k < 68) begin exp_b[k] = (s > 255) ? 8'hFF : 8'(s); k++; end
      end
    end
    hold(1'b0, tail);
  endtask

  task automatic check_words(input string req);
    logic [31:0] d;
    for (int w = 0; w < 17; w++) begin
      rd(6'h10 + 6'(w), d);
      check(d == {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]}, req, d,
            {exp_b[4*w+3], exp_b[4*w+2], exp_b[4*w+1], exp_b[4*w]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R12 reset state
    #1 check(irq_o == 1'b0, "R12", 32'(irq_o), 0);
    rd(6'h06, d); check(d == 0, "R12", d, 0);
    foreach (exp_b[i]) exp_b[i] = 8'h00;
    check_words("R12");

    wr(6'h00, CFG_ON);
    wr(6'h04, 32'h1);

    // table of messages: R1 R2 R3 R4 R5
    for (int v = 0; v < N_VEC; v++) begin
      wr(6'h03, 32'h1);
      wr(6'h05, 32'h1);
      hold(1'b0, 6);
      send(VEC[v][0], VEC[v][1], VEC[v][2], 1, 40);
      #1 check(irq_o == 1'b1, "R3", 32'(irq_o), 1);
      check_words(tag_name(VEC[v][3]));
    end

    // R11: pending status blocks a new capture
    send(6, 6, 3, 1, 40);
    send(VEC[N_VEC-1][0], VEC[N_VEC-1][1], VEC[N_VEC-1][2], 1, 0);
    check_words("R11");

    // R7: clear and mask
    wr(6'h05, 32'h1);
    #1 check(irq_o == 1'b0, "R7", 32'(irq_o), 0);
    rd(6'h06, d); check(d == 0, "R7", d, 0);
    wr(6'h04, 32'h0);
    wr(6'h03, 32'h1);
    send(4, 4, 2, 1, 40);
    rd(6'h06, d); check(d == 1, "R7", d, 1);
    #1 check(irq_o == 1'b0, "R7", 32'(irq_o), 0);
    wr(6'h04, 32'h1);
    #1 check(irq_o == 1'b1, "R7", 32'(irq_o), 1);

    // R6: restart clears the store
    wr(6'h03, 32'h1);
    wr(6'h05, 32'h1);
    foreach (exp_b[i]) exp_b[i] = 8'h00;
    check_words("R6");

    // R8: one enable low -> nothing captured, no status
    wr(6'h00, 32'h0003_0001);
    send(5, 5, 3, 1, 40);
    rd(6'h06, d); check(d == 0, "R8", d, 0);
    foreach (exp_b[i]) exp_b[i] = 8'h00;
    check_words("R8");
    // disable mid-message -> no status
    wr(6'h00, CFG_ON);
    hold(1'b1, 5); hold(1'b0, 4); hold(1'b1, 5);
    wr(6'h00, 32'h0);
    hold(1'b0, 40);
    rd(6'h06, d); check(d == 0, "R8", d, 0);
    wr(6'h00, CFG_ON);

    // R9: de-glitch of 3 ticks rejects a 2-cycle glitch
    wr(6'h03, 32'h1);
    wr(6'h01, 32'h0000_0300);
    hold(1'b1, 2);
    hold(1'b0, 40);
    rd(6'h06, d); check(d == 0, "R9", d, 0);
    foreach (exp_b[i]) exp_b[i] = 8'h00;
    check_words("R9");
    send(6, 5, 2, 1, 40);
    check_words("R9");
    wr(6'h01, 32'h0000_0100);

    // R10: period 3 -> one tick per 4 cycles
    wr(6'h03, 32'h1);
    wr(6'h05, 32'h1);
    wr(6'h02, 32'h3);
    hold(1'b0, 8);
    send(5, 10, 3, 4, 80);
    #1 check(irq_o == 1'b1, "R10", 32'(irq_o), 1);
    check_words("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule